// File: doc/BRIEF.md
# Pulsed Overload Retry Guard

This block supervises the power output of one supply channel. It watches a current-overload comparator and two temperature comparators, and it produces the enable for the output stage plus two status flags that are returned to the control register. Two protection styles are available. In retry mode, an overload switches the output off for a long rest period. The output is then switched back on for a short trial period that is one tenth as long. The sequence returns to normal operation only after a complete trial period in which no overload was seen. In clamp mode, an analog limiter outside this block holds the current, so the output stays on and the overload flag simply follows the comparator.

Thermal protection uses two comparators: one fires above the upper temperature and one fires below the lower temperature. Between the two thresholds the block keeps its previous state. While the channel is disabled, the output is off and the sequencer is held idle. All comparator inputs are asynchronous. Each one passes through a two-stage synchronizer and a filter that accepts a new level only after it has been stable for a set number of samples. All durations are parameters counted in system-clock cycles.

Top module: `lnb_overload_guard`

## Requirements
- R1: While reset is asserted, and on the first sample after reset, `out_en`, `flag_ovl` and `flag_hot` are 0. After reset is released with `enable`=1 and no fault, the output comes back on.
- R2: When `enable` is 0, `out_en` and `flag_ovl` are 0 on the next cycle and the retry sequence is cleared. `out_en` can only rise if `enable` was 1 on the previous cycle.
- R3: In retry mode (`mode_static`=0), a raw overload that rises turns `out_en` off at the FILT_LEN+4th rising edge after the change, counting the first edge that samples it. `flag_ovl` rises on the same cycle, and the output stays off for exactly OFF_CYCLES cycles.
- R4: After the rest period, `out_en` is 1 for exactly ON_CYCLES = OFF_CYCLES/ON_DIV cycles. If the overload is still present, a new rest period of OFF_CYCLES follows.
- R5: Any filtered overload sampled during a trial period forces a further rest period, even if the overload has gone by the end of the trial. After a clean trial, `out_en` stays 1 and `flag_ovl` falls ON_CYCLES cycles after `out_en` rose.
- R6: In clamp mode (`mode_static`=1), `out_en` stays 1 while enabled and not hot, and `flag_ovl` equals the filtered overload gated by `enable`.
- R7: `hot_trip_raw`=1 sets `flag_hot` and forces `out_en` to 0 on the following cycle. `flag_hot` clears only when `cool_raw`=1 and the trip is absent. With both inputs at 0, the state is held. The trip input has priority.
- R8: A switch from clamp to retry mode while the overload is present starts a fresh rest period of the full OFF_CYCLES: `out_en` goes low on the second sample. A switch from retry to clamp mode during a rest period turns `out_en` back on by the second sample.
- R9: A raw comparator pulse that lasts FILT_LEN-1 cycles has no effect on any output. A pulse that lasts FILT_LEN cycles is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Channel enable from the control register |
| mode_static | input | 1 | 1 = clamp mode, 0 = pulsed retry mode |
| ovl_raw | input | 1 | Asynchronous overload comparator |
| hot_trip_raw | input | 1 | Asynchronous comparator, above the upper temperature |
| cool_raw | input | 1 | Asynchronous comparator, below the lower temperature |
| out_en | output | 1 | Output stage enable (registered) |
| flag_ovl | output | 1 | Overload status flag (registered) |
| flag_hot | output | 1 | Over-temperature status flag (registered) |

## Verification
A raw comparator change reaches the filtered level after FILT_LEN+2 edges. The sequencer adds one edge and the output register adds another, so an overload in retry mode is seen on `out_en` at the FILT_LEN+4th sample. A change on `enable` or `mode_static` is not filtered: it shows up at the first or second sample. Rest and trial periods are measured by counting falling-edge samples of a constant level and comparing the count with OFF_CYCLES and ON_CYCLES. The table-driven vectors hold each input pattern for twelve cycles, which is longer than every path latency, so they compare only settled values.

// File: rtl/olg_pkg.sv
// Shared types for the overload retry guard.
// Assumes: nothing beyond IEEE 1800-2017.
package olg_pkg;

    // Retry sequencer state
    typedef enum logic [1:0] {
        SEQ_IDLE     = 2'd0,
        SEQ_HOLD_OFF = 2'd1,
        SEQ_PROBE    = 2'd2
    } seq_state_t;

endpackage

// File: rtl/olg_sync_filter.sv
// Synchronizes one asynchronous comparator and accepts a new level only
// after it has been seen on FILT_LEN consecutive samples.
// Assumes: SYNC_STAGES >= 2, FILT_LEN >= 1. Output resets to 0.
module olg_sync_filter #(
    parameter int FILT_LEN    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          run_q;
    logic                   samp;

    // Metastability shift chain
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
    end

    assign samp = sync_q[SYNC_STAGES-1];

    // Stability counter: commit the new level after FILT_LEN matching samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
            dout  <= 1'b0;
        end else if (samp == dout) begin
            run_q <= '0;
        end else if (run_q == CW'(FILT_LEN - 1)) begin
            dout  <= samp;
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/olg_thermal_latch.sv
// Two-threshold thermal state: set by the upper trip, cleared by the lower
// cool indication, held in between. The trip has priority.
// Assumes: inputs are already synchronized and filtered.
module olg_thermal_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic trip,
    input  logic cool,
    output logic hot
);
    // Hysteresis state update
    always_ff @(posedge clk) begin
        if (!rst_n)    hot <= 1'b0;
        else if (trip) hot <= 1'b1;
        else if (cool) hot <= 1'b0;
    end
endmodule

// File: rtl/olg_retry_seq.sv
// Pulsed retry sequencer: on overload, rest for OFF_CYCLES, then try for
// ON_CYCLES. Any overload seen during a trial forces another rest.
// Assumes: ovl is filtered; clear is synchronous and dominates.
module olg_retry_seq
    import olg_pkg::*;
#(
    parameter int OFF_CYCLES = 1000,
    parameter int ON_CYCLES  = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic ovl,
    output logic busy,
    output logic hold_off
);
    localparam int MAXC = (OFF_CYCLES > ON_CYCLES) ? OFF_CYCLES : ON_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);

    seq_state_t    state_q;
    logic [CW-1:0] cnt_q;
    logic          dirty_q;
    logic          dirty_n;

    assign dirty_n  = dirty_q | ovl;
    assign busy     = (state_q != SEQ_IDLE);
    assign hold_off = (state_q == SEQ_HOLD_OFF);

    // Rest / trial state machine with shared period counter
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            dirty_q <= 1'b0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (ovl) begin
                        state_q <= SEQ_HOLD_OFF;
                        cnt_q   <= '0;
                    end
                end
                SEQ_HOLD_OFF: begin
                    if (cnt_q == CW'(OFF_CYCLES - 1)) begin
                        state_q <= SEQ_PROBE;
                        cnt_q   <= '0;
                        dirty_q <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SEQ_PROBE: begin
                    if (cnt_q == CW'(ON_CYCLES - 1)) begin
                        state_q <= dirty_n ? SEQ_HOLD_OFF : SEQ_IDLE;
                        cnt_q   <= '0;
                        dirty_q <= 1'b0;
                    end else begin
                        cnt_q   <= cnt_q + 1'b1;
                        dirty_q <= dirty_n;
                    end
                end
                default: begin
                    state_q <= SEQ_IDLE;
                    cnt_q   <= '0;
                    dirty_q <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/lnb_overload_guard.sv
// Output protection for one supply channel: input filtering, thermal
// hysteresis, pulsed retry or clamp-mode flagging, and registered outputs.
// Assumes: comparator inputs are asynchronous; enable and mode_static are
// synchronous register bits.
module lnb_overload_guard #(
    parameter int OFF_CYCLES = 90_000_000,
    parameter int ON_DIV     = 10,
    parameter int FILT_LEN   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic mode_static,
    input  logic ovl_raw,
    input  logic hot_trip_raw,
    input  logic cool_raw,
    output logic out_en,
    output logic flag_ovl,
    output logic flag_hot
);
    localparam int ON_RAW    = OFF_CYCLES / ON_DIV;
    localparam int ON_CYCLES = (ON_RAW < 1) ? 1 : ON_RAW;
    localparam int N_IN      = 3;

    logic [N_IN-1:0] raw_vec;
    logic [N_IN-1:0] clean_vec;
    logic            ovl_f;
    logic            hot;
    logic            seq_clear;
    logic            seq_busy;
    logic            seq_hold;

    assign raw_vec = {cool_raw, hot_trip_raw, ovl_raw};

    // One synchronizer and filter per comparator input
    for (genvar gi = 0; gi < N_IN; gi++) begin : g_filt
        olg_sync_filter #(.FILT_LEN(FILT_LEN), .SYNC_STAGES(2)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (raw_vec[gi]),
            .dout  (clean_vec[gi])
        );
    end

    assign ovl_f = clean_vec[0];

    olg_thermal_latch u_therm (
        .clk   (clk),
        .rst_n (rst_n),
        .trip  (clean_vec[1]),
        .cool  (clean_vec[2]),
        .hot   (hot)
    );

    assign seq_clear = !enable || mode_static || hot;

    olg_retry_seq #(.OFF_CYCLES(OFF_CYCLES), .ON_CYCLES(ON_CYCLES)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (seq_clear),
        .ovl      (ovl_f),
        .busy     (seq_busy),
        .hold_off (seq_hold)
    );

    // Registered output enable and overload flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_en   <= 1'b0;
            flag_ovl <= 1'b0;
        end else begin
            out_en   <= enable && !hot && !seq_hold;
            flag_ovl <= enable && (mode_static ? ovl_f : seq_busy);
        end
    end

    assign flag_hot = hot;
endmodule

// File: rtl/olg_guard_checker.sv
// Property checker for lnb_overload_guard, attached by bind.
// Assumes: OFF_CYCLES matches the bound instance.
module olg_guard_checker #(
    parameter int OFF_CYCLES = 1000
) (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic mode_static,
    input logic out_en,
    input logic flag_ovl,
    input logic flag_hot
);
    localparam int CW = $clog2(OFF_CYCLES + 2);

    logic [CW-1:0] low_run;

    // Length of the current rest period as seen at the ports
    always_ff @(posedge clk) begin
        if (!rst_n) low_run <= '0;
        else if (!out_en && flag_ovl && enable && !mode_static && !flag_hot) begin
            if (low_run != {CW{1'b1}}) low_run <= low_run + 1'b1;
        end else low_run <= '0;
    end

    assert_en_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!out_en && !flag_ovl));

    assert_rise_needs_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_en) |-> $past(enable));

    assert_hot_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_hot |=> !out_en);

    assert_off_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= CW'(OFF_CYCLES));

    assert_clamp_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_static && $past(mode_static) && enable && !flag_hot) |=> out_en);
endmodule

bind lnb_overload_guard olg_guard_checker #(.OFF_CYCLES(OFF_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .mode_static (mode_static),
    .out_en      (out_en),
    .flag_ovl    (flag_ovl),
    .flag_hot    (flag_hot)
);

// File: tb/lnb_overload_guard_test.sv
module lnb_overload_guard_test;
    localparam int OFF  = 100;
    localparam int DIV  = 10;
    localparam int ON   = OFF / DIV;
    localparam int FILT = 3;
    localparam int LAT  = FILT + 4;
    localparam int NV   = 10;
    // {en, static, ovl, trip, cool, exp_oe, exp_fo, exp_fh}
    localparam logic [7:0] VEC [NV] = '{
        8'b00001_000, 8'b10001_100, 8'b11101_110, 8'b11001_100,
        8'b11010_001, 8'b11000_001, 8'b11001_100, 8'b01101_000,
        8'b01001_000, 8'b10001_100
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, mode_static = 1'b0, ovl_raw = 1'b0;
    logic hot_trip_raw = 1'b0, cool_raw = 1'b0;
    logic out_en, flag_ovl, flag_hot;
    int   n_chk = 0, n_bad = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    lnb_overload_guard #(.OFF_CYCLES(OFF), .ON_DIV(DIV), .FILT_LEN(FILT)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode_static(mode_static),
        .ovl_raw(ovl_raw), .hot_trip_raw(hot_trip_raw), .cool_raw(cool_raw),
        .out_en(out_en), .flag_ovl(flag_ovl), .flag_hot(flag_hot)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count samples, starting with the current one, while out_en == lvl
    task automatic run_len(input logic lvl, output int n);
        n = 0;
        while (out_en == lvl && n < 5000) begin
            n++;
            tick();
        end
    endtask

    // Count samples after a stimulus until out_en == lvl
    task automatic wait_for(input logic lvl, output int n);
        n = 1;
        tick();
        while (out_en != lvl && n < 1000) begin
            n++;
            tick();
        end
    endtask

    initial begin
        int n;
        int bad;
        tick();
        // R1: reset state
        repeat (3) tick();
        chk("R1 out_en in reset", out_en, 0);
        chk("R1 flag_ovl in reset", flag_ovl, 0);
        chk("R1 flag_hot in reset", flag_hot, 0);
        rst_n = 1'b1;

        // Table of settled patterns (R2, R6, R7)
        for (int v = 0; v < NV; v++) begin
            {enable, mode_static, ovl_raw, hot_trip_raw, cool_raw} = VEC[v][7:3];
            repeat (12) tick();
            chk($sformatf("R2/R6/R7 vec%0d out_en", v), out_en, VEC[v][2]);
            chk($sformatf("R2/R6/R7 vec%0d flag_ovl", v), flag_ovl, VEC[v][1]);
            chk($sformatf("R2/R6/R7 vec%0d flag_hot", v), flag_hot, VEC[v][0]);
        end

        // R3/R4/R5: retry timing in pulsed mode
        repeat (10) tick();
        ovl_raw = 1'b1;
        wait_for(1'b0, n);
        chk("R3 shutdown latency", n, LAT);
        chk("R3 flag_ovl with shutdown", flag_ovl, 1);
        run_len(1'b0, n);
        chk("R3 rest length", n, OFF);
        run_len(1'b1, n);
        chk("R4 trial length", n, ON);
        run_len(1'b0, n);
        chk("R4 repeated rest length", n, OFF);
        ovl_raw = 1'b0;
        run_len(1'b1, n);
        chk("R5 dirty trial length", n, ON);
        run_len(1'b0, n);
        chk("R5 rest after dirty trial", n, OFF);
        chk("R5 flag at clean trial start", flag_ovl, 1);
        n = 0;
        while (flag_ovl && n < 1000) begin
            n++;
            tick();
        end
        chk("R5 flag clears after trial", n, ON);
        bad = 0;
        repeat (2 * OFF) begin
            if (!out_en || flag_ovl) bad++;
            tick();
        end
        chk("R5 stays recovered", bad, 0);

        // R8: mode switches during an overload
        ovl_raw = 1'b1;
        wait_for(1'b0, n);
        repeat (5) tick();
        mode_static = 1'b1;
        tick();
        tick();
        chk("R8 clamp switch restores out_en", out_en, 1);
        chk("R6 clamp flag mirrors overload", flag_ovl, 1);
        repeat (10) tick();
        chk("R6 clamp out_en held", out_en, 1);
        mode_static = 1'b0;
        wait_for(1'b0, n);
        chk("R8 fresh rest delay", n, 2);
        run_len(1'b0, n);
        chk("R8 fresh rest length", n, OFF);
        ovl_raw = 1'b0;
        repeat (2 * (OFF + ON) + 30) tick();
        chk("R5 recovered after mode test", out_en, 1);
        chk("R5 flag low after mode test", flag_ovl, 0);

        // R9: glitch rejection
        ovl_raw = 1'b1;
        repeat (FILT - 1) tick();
        ovl_raw = 1'b0;
        bad = 0;
        repeat (30) begin
            if (!out_en || flag_ovl) bad++;
            tick();
        end
        chk("R9 short pulse ignored", bad, 0);
        ovl_raw = 1'b1;
        repeat (FILT) tick();
        ovl_raw = 1'b0;
        wait_for(1'b0, n);
        chk("R9 full pulse accepted", (n < 20) ? 1 : 0, 1);
        repeat (2 * (OFF + ON) + 30) tick();
        chk("R9 recovered after pulse", out_en, 1);

        // R1: reset in the middle of a rest period
        ovl_raw = 1'b1;
        wait_for(1'b0, n);
        ovl_raw = 1'b0;
        rst_n = 1'b0;
        tick();
        chk("R1 mid-run reset out_en", out_en, 0);
        chk("R1 mid-run reset flag_ovl", flag_ovl, 0);
        rst_n = 1'b1;
        repeat (10) tick();
        chk("R1 out_en after release", out_en, 1);
        chk("R1 flag_ovl after release", flag_ovl, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule